// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block steps through a linked chain of transfer descriptors kept in a small register table that the CPU fills through a write port. Each descriptor gives a word count, a next link, an alternate link and three flags: end of chain, halt and interrupt. For every descriptor the sequencer requests one word per handshake until the count is used up. It then follows the descriptor's link, stops, or returns to the head of the chain.

A typical chain starts with a header descriptor that carries a count. The chain halts there and interrupts the CPU. The CPU inspects the header and kicks the sequencer again, choosing the short normal branch or the longer alternate branch. The chosen branch then runs to its end without further help. At the end the sequencer reloads the head descriptor. A chain is either free-running, in which case it starts again by itself, or kick-started, in which case it waits for a CPU kick before its first descriptor. The memory bus and the data path are not part of the block. A request/grant handshake per word stands in for them.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the sequencer is idle: `stat_busy`, `stat_halted`, `xfer_req`, `irq_pulse` and `kick_err` are 0, `chain_cnt` is 0 and `cur_idx` equals `cfg_head_idx`.
- R2: When `cfg_free_run` is 0, the idle sequencer waits with `stat_busy` at 0 until a kick arrives. When `cfg_free_run` is 1, it leaves idle on the next clock edge with no kick.
- R3: `xfer_req` is high only while a descriptor with words still owed is running. A word moves only in a cycle with `xfer_req` and `xfer_gnt` both high. A descriptor with count N completes on the clock edge of its Nth moved word.
- R4: A descriptor with a count of 0 completes in one cycle and never raises `xfer_req`.
- R5: When a descriptor whose halt flag is set completes (and its end flag is clear), the sequencer halts: `stat_halted` is 1 and `cur_idx` stays on that descriptor until a kick.
- R6: A kick while halted resumes at the descriptor's next link when `kick_alt` is 0, and at its alternate link when `kick_alt` is 1.
- R7: A completed descriptor with its halt and end flags clear moves on to its next link in the following cycle with no kick.
- R8: `irq_pulse` is high for exactly the completion cycle of a descriptor whose interrupt flag is set. For a nonzero count this is the cycle in which its last word moves. Descriptors with the flag clear complete silently.
- R9: When a descriptor with its end flag set completes, `cur_idx` reloads `cfg_head_idx`, the sequencer returns to idle and `chain_cnt` increments by one. The end flag takes priority over the halt flag.
- R10: A kick that arrives while the sequencer is not waiting for one has no effect on the walk and sets `kick_err`. This covers the running state and the idle state in free-running mode. `kick_err` stays set until reset.
- R11: A descriptor is written as `wr_data` with bits [9:0] = word count, [13:10] = next index, [17:14] = alternate index, bit 18 = end flag, bit 19 = halt flag and bit 20 = interrupt flag, stored at entry `wr_idx` when `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_free_run | input | 1 | 1: chain restarts by itself; 0: chain waits for a kick |
| cfg_head_idx | input | 4 | Index of the chain's head descriptor |
| wr_en | input | 1 | Descriptor table write strobe |
| wr_idx | input | 4 | Descriptor table write index |
| wr_data | input | 21 | Descriptor word to store |
| kick_valid | input | 1 | CPU kick |
| kick_alt | input | 1 | Branch select sent with a kick (1 = alternate link) |
| xfer_req | output | 1 | Word transfer request |
| xfer_gnt | input | 1 | Word transfer grant |
| cur_idx | output | 4 | Index of the current descriptor |
| irq_pulse | output | 1 | One-cycle interrupt at completion of a flagged descriptor |
| kick_err | output | 1 | Sticky flag for a kick that arrived at the wrong time |
| stat_busy | output | 1 | Sequencer is running a descriptor |
| stat_halted | output | 1 | Sequencer is halted and waiting for a kick |
| chain_cnt | output | 8 | Number of chains completed since reset |

## Verification
The sharpest overlap is a CPU kick that lands in the same cycle as the last word of the header descriptor. In that cycle the interrupt pulses and the halt takes effect, but the sequencer is still running, so the kick must be rejected. The bench grants two header words, then drives the kick together with the grant of the third word. It expects `irq_pulse` high in that cycle, and `stat_halted` with `kick_err` set and `cur_idx` still on the header in the next cycle. A second, legal kick must then resume normally.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int CNT_W = 10;
    localparam int IDX_W = 4;

    typedef struct packed {
        logic             irq;
        logic             halt;
        logic             last;
        logic [IDX_W-1:0] alt;
        logic [IDX_W-1:0] nxt;
        logic [CNT_W-1:0] cnt;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/dchain_desc_table.sv
module dchain_desc_table
    import dchain_pkg::*;
#(
    parameter int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);
    desc_t row_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        desc_t row_d;

        always_comb begin
            row_d = row_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                row_d = wr_desc;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[g] <= '0;
            end else begin
                row_q[g] <= row_d;
            end
        end
    end

    assign rd_desc = row_q[rd_idx];
endmodule

// File: rtl/dchain_word_ctr.sv
module dchain_word_ctr
    import dchain_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len,
    input  logic             accept,
    input  logic             restart,
    output logic             more,
    output logic             final_beat
);
    logic [CNT_W-1:0] done_d, done_q;

    always_comb begin
        more       = done_q < len;
        final_beat = accept && (({1'b0, done_q} + 1'b1) == {1'b0, len});
        done_d     = done_q;
        if (restart) begin
            done_d = '0;
        end else if (accept) begin
            done_d = done_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            done_q <= done_d;
        end
    end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dchain_pkg::*;
#(
    parameter int CHAIN_CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_free_run,
    input  logic [IDX_W-1:0]       cfg_head_idx,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DESC_W-1:0]      wr_data,
    input  logic                   kick_valid,
    input  logic                   kick_alt,
    output logic                   xfer_req,
    input  logic                   xfer_gnt,
    output logic [IDX_W-1:0]       cur_idx,
    output logic                   irq_pulse,
    output logic                   kick_err,
    output logic                   stat_busy,
    output logic                   stat_halted,
    output logic [CHAIN_CNT_W-1:0] chain_cnt
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        seq_st_e                st;
        logic [IDX_W-1:0]       idx;
        logic                   err;
        logic [CHAIN_CNT_W-1:0] chains;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    desc_t cur;
    logic  running, more, final_beat, accept, entry_done, kick_ok, restart;

    dchain_desc_table #(.DEPTH(DEPTH)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_desc (desc_t'(wr_data)),
        .rd_idx  (ctl_q.idx),
        .rd_desc (cur)
    );

    dchain_word_ctr ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .len        (cur.cnt),
        .accept     (accept),
        .restart    (restart),
        .more       (more),
        .final_beat (final_beat)
    );

    always_comb begin
        running    = (ctl_q.st == ST_RUN);
        xfer_req   = running && more;
        accept     = xfer_req && xfer_gnt;
        entry_done = running && ((cur.cnt == '0) || final_beat);
        restart    = !running || entry_done;
        irq_pulse  = entry_done && cur.irq;
        kick_ok    = kick_valid &&
                     ((ctl_q.st == ST_HALT) || ((ctl_q.st == ST_IDLE) && !cfg_free_run));

        ctl_d = ctl_q;
        if (kick_valid && !kick_ok) begin
            ctl_d.err = 1'b1;
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.idx = cfg_head_idx;
                if (cfg_free_run || kick_ok) begin
                    ctl_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (entry_done) begin
                    if (cur.last) begin
                        ctl_d.idx    = cfg_head_idx;
                        ctl_d.chains = ctl_q.chains + 1'b1;
                        ctl_d.st     = ST_IDLE;
                    end else if (cur.halt) begin
                        ctl_d.st = ST_HALT;
                    end else begin
                        ctl_d.idx = cur.nxt;
                    end
                end
            end
            ST_HALT: begin
                if (kick_ok) begin
                    ctl_d.idx = kick_alt ? cur.alt : cur.nxt;
                    ctl_d.st  = ST_RUN;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.idx    <= cfg_head_idx;
            ctl_q.err    <= 1'b0;
            ctl_q.chains <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cur_idx     = ctl_q.idx;
    assign kick_err    = ctl_q.err;
    assign stat_busy   = running;
    assign stat_halted = (ctl_q.st == ST_HALT);
    assign chain_cnt   = ctl_q.chains;
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk
    import dchain_pkg::*;
#(
    parameter int CHAIN_CNT_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [IDX_W-1:0]       cfg_head_idx,
    input logic                   kick_valid,
    input logic                   xfer_req,
    input logic                   xfer_gnt,
    input logic [IDX_W-1:0]       cur_idx,
    input logic                   irq_pulse,
    input logic                   kick_err,
    input logic                   stat_busy,
    input logic                   stat_halted,
    input logic [CHAIN_CNT_W-1:0] chain_cnt
);
    // R3
    no_req_when_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_busy |-> !xfer_req);

    // R3
    req_held_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_gnt) |=> (xfer_req && $stable(cur_idx)));

    // R5
    halt_holds_without_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_halted && !kick_valid) |=> (stat_halted && $stable(cur_idx)));

    // R8
    irq_only_while_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> stat_busy);

    // R9
    reload_on_chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_cnt != $past(chain_cnt)) |-> (cur_idx == cfg_head_idx && !stat_busy));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_err |=> kick_err);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.CHAIN_CNT_W(CHAIN_CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_head_idx (cfg_head_idx),
    .kick_valid   (kick_valid),
    .xfer_req     (xfer_req),
    .xfer_gnt     (xfer_gnt),
    .cur_idx      (cur_idx),
    .irq_pulse    (irq_pulse),
    .kick_err     (kick_err),
    .stat_busy    (stat_busy),
    .stat_halted  (stat_halted),
    .chain_cnt    (chain_cnt)
);

// File: tb/dma_chain_seq_tb_top.sv
`timescale 1ns/1ps
module dma_chain_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_free_run = 1'b0;
    logic [3:0]  cfg_head_idx = 4'd2;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [20:0] wr_data = '0;
    logic        kick_valid = 1'b0;
    logic        kick_alt = 1'b0;
    logic        xfer_gnt = 1'b0;
    logic        xfer_req, irq_pulse, kick_err, stat_busy, stat_halted;
    logic [3:0]  cur_idx;
    logic [7:0]  chain_cnt;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_chain_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_free_run(cfg_free_run), .cfg_head_idx(cfg_head_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .kick_valid(kick_valid), .kick_alt(kick_alt),
        .xfer_req(xfer_req), .xfer_gnt(xfer_gnt), .cur_idx(cur_idx),
        .irq_pulse(irq_pulse), .kick_err(kick_err), .stat_busy(stat_busy),
        .stat_halted(stat_halted), .chain_cnt(chain_cnt)
    );

    typedef struct packed {
        logic        alt;
        logic [7:0]  pat;
        logic [7:0]  exp_words;
        logic [3:0]  exp_irqs;
        logic [15:0] exp_mask;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 8'hFF, 8'd7, 4'd2, 16'h000C},
        '{1'b1, 8'hFF, 8'd6, 4'd2, 16'h00E4},
        '{1'b0, 8'hA5, 8'd7, 4'd2, 16'h000C},
        '{1'b1, 8'h6D, 8'd6, 4'd2, 16'h00E4}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [20:0] mk(input bit irq, input bit halt, input bit last,
                                       input logic [3:0] alt, input logic [3:0] nxt,
                                       input logic [9:0] cnt);
        return {irq, halt, last, alt, nxt, cnt};
    endfunction

    // R11: layout {irq, halt, last, alt, next, count}
    task automatic program_table();
        logic [20:0] d [5];
        logic [3:0]  a [5];
        a[0] = 4'd2; d[0] = mk(1, 1, 0, 4'd5, 4'd3, 10'd3);
        a[1] = 4'd3; d[1] = mk(1, 0, 1, 4'd0, 4'd0, 10'd4);
        a[2] = 4'd5; d[2] = mk(0, 0, 0, 4'd0, 4'd6, 10'd2);
        a[3] = 4'd6; d[3] = mk(0, 0, 0, 4'd0, 4'd7, 10'd0);
        a[4] = 4'd7; d[4] = mk(1, 0, 1, 4'd0, 4'd0, 10'd1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = a[i]; wr_data = d[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        kick_valid = 1'b0; xfer_gnt = 1'b0; cfg_free_run = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int words, irqs, base;
        logic [15:0] mask;
        bit kicked2;

        do_reset();
        #2;
        // R1
        chk(!stat_busy && !stat_halted, "R1 idle", {stat_busy, stat_halted}, 0);
        chk(!xfer_req && !irq_pulse && !kick_err, "R1 outputs", {xfer_req, irq_pulse, kick_err}, 0);
        chk(chain_cnt == 0 && cur_idx == 4'd2, "R1 idx/count", cur_idx, 2);
        program_table();

        // R2: kick-started chain stays idle
        repeat (5) @(negedge clk);
        #2;
        chk(!stat_busy, "R2 waits for kick", stat_busy, 0);

        // coincidence: kick together with last header word
        @(negedge clk); kick_valid = 1'b1; kick_alt = 1'b0;
        @(negedge clk); kick_valid = 1'b0; xfer_gnt = 1'b1;
        #2 chk(stat_busy && xfer_req, "R2 started by kick", stat_busy, 1);
        @(negedge clk);
        @(negedge clk); kick_valid = 1'b1; kick_alt = 1'b1;
        #2 chk(irq_pulse == 1'b1, "R8 irq on last header word", irq_pulse, 1);
        @(negedge clk); kick_valid = 1'b0; xfer_gnt = 1'b0;
        #2;
        chk(stat_halted, "R5 halted after header", stat_halted, 1);
        chk(cur_idx == 4'd2, "R5 index held", cur_idx, 2);
        chk(kick_err, "R10 early kick flagged", kick_err, 1);
        @(negedge clk); kick_valid = 1'b1; kick_alt = 1'b0;
        @(negedge clk); kick_valid = 1'b0;
        #2;
        chk(stat_busy && cur_idx == 4'd3, "R6 normal link", cur_idx, 3);
        chk(kick_err, "R10 sticky", kick_err, 1);
        // R10: kick while running is ignored
        @(negedge clk); kick_valid = 1'b1; kick_alt = 1'b1;
        @(negedge clk); kick_valid = 1'b0;
        #2 chk(stat_busy && cur_idx == 4'd3, "R10 running kick ignored", cur_idx, 3);
        xfer_gnt = 1'b1;
        for (int c = 0; c < 20 && stat_busy; c++) @(negedge clk);
        #2;
        chk(chain_cnt == 1 && cur_idx == 4'd2 && !stat_busy, "R9 reload", cur_idx, 2);
        xfer_gnt = 1'b0;

        // vector walk
        do_reset();
        program_table();
        foreach (VECS[v]) begin
            words = 0; irqs = 0; mask = '0; kicked2 = 0; base = chain_cnt;
            @(negedge clk); kick_valid = 1'b1; kick_alt = 1'b0; xfer_gnt = 1'b0;
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                kick_valid = 1'b0;
                if (stat_halted && !kicked2) begin
                    chk(words == 3 && irqs == 1, "R5 header halt", words, 3);
                    chk(cur_idx == 4'd2, "R5 header index", cur_idx, 2);
                    kick_valid = 1'b1; kick_alt = VECS[v].alt; kicked2 = 1;
                end else if (kicked2 && !stat_busy && !stat_halted) begin
                    break;
                end
                xfer_gnt = VECS[v].pat[c % 8];
                #2;
                if (stat_busy) mask[cur_idx] = 1'b1;
                if (stat_busy && cur_idx == 4'd6) chk(!xfer_req, "R4 zero count no req", xfer_req, 0);
                if (xfer_req && xfer_gnt) words++;
                if (irq_pulse) begin
                    irqs++;
                    chk(xfer_req && xfer_gnt, "R8 irq with last word", xfer_req, 1);
                end
            end
            xfer_gnt = 1'b0;
            chk(words == VECS[v].exp_words, "R3 word total", words, VECS[v].exp_words);
            chk(irqs == VECS[v].exp_irqs, "R8 irq total", irqs, VECS[v].exp_irqs);
            chk(mask == VECS[v].exp_mask, "R6 R7 path", mask, VECS[v].exp_mask);
            chk(cur_idx == 4'd2 && chain_cnt == base + 1, "R9 reload count", chain_cnt, base + 1);
            chk(!kick_err, "R10 no error", kick_err, 0);
        end

        // free-running restart
        do_reset();
        program_table();
        cfg_free_run = 1'b1; xfer_gnt = 1'b1;
        @(negedge clk);
        #2 chk(stat_busy, "R2 free run starts", stat_busy, 1);
        for (int c = 0; c < 20 && !stat_halted; c++) @(negedge clk);
        kick_valid = 1'b1; kick_alt = 1'b0;
        @(negedge clk); kick_valid = 1'b0;
        for (int c = 0; c < 20 && chain_cnt == 0; c++) @(negedge clk);
        #2 chk(!stat_busy && cur_idx == 4'd2, "R9 free run reload", cur_idx, 2);
        kick_valid = 1'b1;
        @(negedge clk); kick_valid = 1'b0;
        #2;
        chk(stat_busy, "R2 free run restarts", stat_busy, 1);
        chk(kick_err, "R10 kick in free idle", kick_err, 1);
        cfg_free_run = 1'b0; xfer_gnt = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule